// File: doc/BRIEF.md
# NAND Interface Timing Calculator

This block turns a set of flash timing requirements, each given in picoseconds, into the cycle counts a NAND flash controller programs into its timing logic. One start strobe latches the requirements: the minimum read cycle time, address setup, data setup, data hold, write-to-busy delay, page read time and maximum read access time. The block then picks one of three controller clock rates and works out the setup and hold cycle counts, a busy timeout and a read-sample delay code. It raises a single-cycle done flag when every result is ready.

The arithmetic runs on one shared restoring divider, one quotient bit per cycle, so a full computation takes a fixed number of cycles. All pins are plain control and status signals. There is no stream interface and no back-pressure: a start strobe is taken only while `busy` is low and is otherwise dropped. The results stay on the outputs until the next computation finishes.

Top module: `nand_tcalc`

## Requirements
- R1: If the read cycle time is 30000 ps or more, `clk_sel` is 0 (22 MHz, period 45454 ps) and `wstrobe_dly` is 1.
- R2: If the read cycle time is 25000 to 29999 ps, `clk_sel` is 1 (80 MHz, period 12500 ps). Below 25000 ps, `clk_sel` is 2 (100 MHz, period 10000 ps). In both cases `wstrobe_dly` is 0.
- R3: `addr_cyc`, `dsetup_cyc` and `dhold_cyc` are the address setup, data setup and data hold times divided by the selected period and rounded up. A time of zero gives zero cycles.
- R4: `busy_tmo` is the rounded-up cycle count of (write-to-busy + page read time) times 4096, truncated to 32 bits. The sum is formed without overflow.
- R5: The reference period is half the clock period, rounded down, when the clock period is above `DLL_THRESH_PS` (default 16000). Otherwise it equals the clock period.
- R6: Let P be `dsetup_cyc` times the period. `rdn_factor` is floor(8 × (tREA + 4000 − P) / reference period). It is 0 when tREA + 4000 is not greater than P.
- R7: `dll_en` is 1 only when `rdn_factor` is nonzero. `half_per` is 1 only when `rdn_factor` is nonzero and the halved reference period was used.
- R8: After an accepted start, `busy` is high until `done` rises. `done` is high for exactly one cycle, 5 × (DW + 6) = 190 cycles after the start edge, and `busy` falls on the same edge.
- R9: A start strobe while `busy` is high is ignored, and changing the inputs after the start edge has no effect. Outputs hold their values between done pulses.
- R10: During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, taken when busy is low |
| trc_min_ps | input | 32 | Minimum read cycle time |
| tals_ps | input | 32 | Address setup time |
| tds_ps | input | 32 | Data setup time |
| tdh_ps | input | 32 | Data hold time |
| twb_ps | input | 32 | Write-to-busy delay |
| tr_ps | input | 32 | Page read time |
| trea_ps | input | 32 | Maximum read access time |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| clk_sel | output | 2 | Clock selection code (0/1/2) |
| wstrobe_dly | output | 1 | Write-strobe 4 to 8 ns delay select |
| addr_cyc | output | 32 | Address setup cycles |
| dsetup_cyc | output | 32 | Data setup cycles |
| dhold_cyc | output | 32 | Data hold cycles |
| busy_tmo | output | 32 | Busy timeout count |
| half_per | output | 1 | Halved reference period in use |
| dll_en | output | 1 | Delay line enable |
| rdn_factor | output | 32 | Read-sample delay in eighth-period steps |

## Verification
The assertions assume that reset is applied before the first start. They also assume that the requirement values matter only on the edge where a start is accepted, so the checker keeps its own copy of the values taken on that edge. The stimulus tests this assumption on purpose: it changes the inputs freely once a computation is running and fires a second start in the middle of a run. Each value is a 32-bit unsigned number. The stimulus includes a write-to-busy plus page-read sum that does not fit in 32 bits, to check that the sum is formed without overflow.

// File: rtl/nand_tcalc_pkg.sv
package nand_tcalc_pkg;
  typedef enum logic [1:0] {CLK_SLOW = 2'd0, CLK_MID = 2'd1, CLK_FAST = 2'd2} clk_mode_e;
  typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_WAIT} seq_e;
  typedef enum logic [2:0] {J_ALS = 3'd0, J_DS = 3'd1, J_DH = 3'd2, J_BUSY = 3'd3, J_DLY = 3'd4} job_e;
endpackage

// File: rtl/nand_tcalc_div.sv
module nand_tcalc_div #(
  parameter int NW = 36,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [DW-1:0] quo,
  output logic [NW-1:0] rem
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] acc, q;
  logic [CW-1:0] cnt;
  logic          run;
  logic [NW-1:0] shifted, den_ext;
  logic          fits;

  always_comb begin
    shifted = {acc[NW-2:0], q[NW-1]};
    den_ext = NW'(den);
    fits    = (shifted >= den_ext);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      q    <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else if (start && !run) begin
      acc  <= '0;
      q    <= num;
      cnt  <= CW'(NW);
      run  <= 1'b1;
      done <= 1'b0;
    end else if (run) begin
      acc <= fits ? (shifted - den_ext) : shifted;
      q   <= {q[NW-2:0], fits};
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) begin
        run  <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign quo = q[DW-1:0];
  assign rem = acc;
endmodule

// File: rtl/nand_tcalc_mode.sv
module nand_tcalc_mode
  import nand_tcalc_pkg::*;
#(
  parameter int DW            = 32,
  parameter int SLOW_HZ       = 22000000,
  parameter int MID_HZ        = 80000000,
  parameter int FAST_HZ       = 100000000,
  parameter int SLOW_TRC_PS   = 30000,
  parameter int MID_TRC_PS    = 25000,
  parameter int DLL_THRESH_PS = 16000
) (
  input  logic [DW-1:0] trc_ps,
  output clk_mode_e     mode,
  output logic [DW-1:0] period,
  output logic [DW-1:0] ref_period,
  output logic          half,
  output logic          wdly
);
  localparam logic [63:0] PS_PER_SEC = 64'd1000000000000;
  localparam logic [DW-1:0] PER_SLOW = DW'(PS_PER_SEC / 64'(SLOW_HZ));
  localparam logic [DW-1:0] PER_MID  = DW'(PS_PER_SEC / 64'(MID_HZ));
  localparam logic [DW-1:0] PER_FAST = DW'(PS_PER_SEC / 64'(FAST_HZ));

  always_comb begin
    if (trc_ps >= DW'(SLOW_TRC_PS)) begin
      mode = CLK_SLOW; period = PER_SLOW; wdly = 1'b1;
    end else if (trc_ps >= DW'(MID_TRC_PS)) begin
      mode = CLK_MID;  period = PER_MID;  wdly = 1'b0;
    end else begin
      mode = CLK_FAST; period = PER_FAST; wdly = 1'b0;
    end
    half       = (period > DW'(DLL_THRESH_PS));
    ref_period = half ? (period >> 1) : period;
  end
endmodule

// File: rtl/nand_tcalc.sv
module nand_tcalc
  import nand_tcalc_pkg::*;
#(
  parameter int DW             = 32,
  parameter int SLOW_HZ        = 22000000,
  parameter int MID_HZ         = 80000000,
  parameter int FAST_HZ        = 100000000,
  parameter int SLOW_TRC_PS    = 30000,
  parameter int MID_TRC_PS     = 25000,
  parameter int DLL_THRESH_PS  = 16000,
  parameter int READ_MARGIN_PS = 4000,
  parameter int BUSY_SHIFT     = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] trc_min_ps,
  input  logic [DW-1:0] tals_ps,
  input  logic [DW-1:0] tds_ps,
  input  logic [DW-1:0] tdh_ps,
  input  logic [DW-1:0] twb_ps,
  input  logic [DW-1:0] tr_ps,
  input  logic [DW-1:0] trea_ps,
  output logic          busy,
  output logic          done,
  output logic [1:0]    clk_sel,
  output logic          wstrobe_dly,
  output logic [DW-1:0] addr_cyc,
  output logic [DW-1:0] dsetup_cyc,
  output logic [DW-1:0] dhold_cyc,
  output logic [DW-1:0] busy_tmo,
  output logic          half_per,
  output logic          dll_en,
  output logic [DW-1:0] rdn_factor
);
  localparam int NW = DW + 4;

  seq_e st;
  job_e job;
  logic [DW-1:0] l_trc, l_tals, l_tds, l_tdh, l_twb, l_tr, l_trea;
  logic [DW-1:0] w_als, w_ds, w_dh, w_busy;

  clk_mode_e     mode;
  logic [DW-1:0] period, ref_period;
  logic          half, wdly;

  nand_tcalc_mode #(
    .DW(DW), .SLOW_HZ(SLOW_HZ), .MID_HZ(MID_HZ), .FAST_HZ(FAST_HZ),
    .SLOW_TRC_PS(SLOW_TRC_PS), .MID_TRC_PS(MID_TRC_PS), .DLL_THRESH_PS(DLL_THRESH_PS)
  ) u_mode (
    .trc_ps(l_trc), .mode(mode), .period(period), .ref_period(ref_period),
    .half(half), .wdly(wdly)
  );

  logic          div_start, div_done;
  logic [NW-1:0] div_num, div_rem;
  logic [DW-1:0] div_den, div_quo, ceil_q;
  logic [63:0]   pulse_ps, budget_ps, slack_ps;
  logic [NW-1:0] dly_num;

  always_comb begin
    pulse_ps  = 64'(w_ds) * 64'(period);
    budget_ps = 64'(l_trea) + 64'(READ_MARGIN_PS);
    slack_ps  = budget_ps - pulse_ps;
    dly_num   = (budget_ps > pulse_ps) ? NW'(slack_ps << 3) : '0;
    case (job)
      J_ALS:   div_num = NW'(l_tals);
      J_DS:    div_num = NW'(l_tds);
      J_DH:    div_num = NW'(l_tdh);
      J_BUSY:  div_num = NW'(l_twb) + NW'(l_tr);
      default: div_num = dly_num;
    endcase
    div_den   = (job == J_DLY) ? ref_period : period;
    div_start = (st == ST_LAUNCH);
    ceil_q    = div_quo + DW'(div_rem != '0);
  end

  nand_tcalc_div #(.NW(NW), .DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num), .den(div_den),
    .done(div_done), .quo(div_quo), .rem(div_rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; job <= J_ALS;
      {l_trc, l_tals, l_tds, l_tdh, l_twb, l_tr, l_trea} <= '0;
      {w_als, w_ds, w_dh, w_busy} <= '0;
      busy <= 1'b0; done <= 1'b0;
      clk_sel <= '0; wstrobe_dly <= 1'b0;
      addr_cyc <= '0; dsetup_cyc <= '0; dhold_cyc <= '0; busy_tmo <= '0;
      half_per <= 1'b0; dll_en <= 1'b0; rdn_factor <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          l_trc <= trc_min_ps; l_tals <= tals_ps; l_tds <= tds_ps; l_tdh <= tdh_ps;
          l_twb <= twb_ps; l_tr <= tr_ps; l_trea <= trea_ps;
          job  <= J_ALS;
          st   <= ST_LAUNCH;
          busy <= 1'b1;
        end
        ST_LAUNCH: st <= ST_WAIT;
        default: if (div_done) begin
          case (job)
            J_ALS:  w_als  <= ceil_q;
            J_DS:   w_ds   <= ceil_q;
            J_DH:   w_dh   <= ceil_q;
            J_BUSY: w_busy <= ceil_q;
            default: ;
          endcase
          if (job == J_DLY) begin
            clk_sel     <= mode;
            wstrobe_dly <= wdly;
            addr_cyc    <= w_als;
            dsetup_cyc  <= w_ds;
            dhold_cyc   <= w_dh;
            busy_tmo    <= w_busy << BUSY_SHIFT;
            rdn_factor  <= div_quo;
            dll_en      <= (div_quo != '0);
            half_per    <= half && (div_quo != '0);
            done        <= 1'b1;
            busy        <= 1'b0;
            st          <= ST_IDLE;
          end else begin
            job <= job_e'(job + 3'd1);
            st  <= ST_LAUNCH;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/nand_tcalc_chk.sv
module nand_tcalc_chk #(
  parameter int DW            = 32,
  parameter int SLOW_HZ       = 22000000,
  parameter int MID_HZ        = 80000000,
  parameter int FAST_HZ       = 100000000,
  parameter int SLOW_TRC_PS   = 30000,
  parameter int MID_TRC_PS    = 25000,
  parameter int DLL_THRESH_PS = 16000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [DW-1:0] trc_min_ps,
  input logic [DW-1:0] tals_ps,
  input logic          busy,
  input logic          done,
  input logic [1:0]    clk_sel,
  input logic          wstrobe_dly,
  input logic [DW-1:0] addr_cyc,
  input logic [DW-1:0] dsetup_cyc,
  input logic [DW-1:0] dhold_cyc,
  input logic [DW-1:0] busy_tmo,
  input logic          half_per,
  input logic          dll_en,
  input logic [DW-1:0] rdn_factor
);
  localparam logic [63:0] PS_PER_SEC = 64'd1000000000000;
  localparam logic [63:0] P0 = PS_PER_SEC / 64'(SLOW_HZ);
  localparam logic [63:0] P1 = PS_PER_SEC / 64'(MID_HZ);
  localparam logic [63:0] P2 = PS_PER_SEC / 64'(FAST_HZ);

  logic [DW-1:0] c_trc, c_tals;
  logic [63:0]   sel_per;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_trc <= '0; c_tals <= '0;
    end else if (start && !busy) begin
      c_trc <= trc_min_ps; c_tals <= tals_ps;
    end
  end

  always_comb begin
    case (clk_sel)
      2'd0:    sel_per = P0;
      2'd1:    sel_per = P1;
      default: sel_per = P2;
    endcase
  end

  a_r1_slow_mode: assert property (@(posedge clk) disable iff (!rst_n)
    done && (c_trc >= DW'(SLOW_TRC_PS)) |-> (clk_sel == 2'd0) && wstrobe_dly);
  a_r2_fast_mode: assert property (@(posedge clk) disable iff (!rst_n)
    done && (c_trc < DW'(MID_TRC_PS)) |-> (clk_sel == 2'd2) && !wstrobe_dly);
  a_r3_addr_ceil: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (64'(addr_cyc) * sel_per >= 64'(c_tals)) &&
             ((addr_cyc == '0) || (64'(addr_cyc - DW'(1)) * sel_per < 64'(c_tals))));
  a_r4_busy_scaled: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_tmo[11:0] == 12'd0));
  a_r5_half_long: assert property (@(posedge clk) disable iff (!rst_n)
    half_per |-> (sel_per > 64'(DLL_THRESH_PS)));
  a_r7_half_dll: assert property (@(posedge clk) disable iff (!rst_n)
    half_per |-> dll_en && (rdn_factor != '0));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({clk_sel, wstrobe_dly, addr_cyc, dsetup_cyc, dhold_cyc,
                       busy_tmo, half_per, dll_en, rdn_factor}));
endmodule

bind nand_tcalc nand_tcalc_chk #(
  .DW(DW), .SLOW_HZ(SLOW_HZ), .MID_HZ(MID_HZ), .FAST_HZ(FAST_HZ),
  .SLOW_TRC_PS(SLOW_TRC_PS), .MID_TRC_PS(MID_TRC_PS), .DLL_THRESH_PS(DLL_THRESH_PS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .trc_min_ps(trc_min_ps), .tals_ps(tals_ps),
  .busy(busy), .done(done), .clk_sel(clk_sel), .wstrobe_dly(wstrobe_dly),
  .addr_cyc(addr_cyc), .dsetup_cyc(dsetup_cyc), .dhold_cyc(dhold_cyc),
  .busy_tmo(busy_tmo), .half_per(half_per), .dll_en(dll_en), .rdn_factor(rdn_factor)
);

// File: tb/nand_tcalc_bench.sv
module nand_tcalc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 190;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] trc, tals, tds, tdh, twb, tr, trea;
  logic busy, done, wstrobe_dly, half_per, dll_en;
  logic [1:0] clk_sel;
  logic [31:0] addr_cyc, dsetup_cyc, dhold_cyc, busy_tmo, rdn_factor;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_tcalc u_nand_tcalc (
    .clk(clk), .rst_n(rst_n), .start(start), .trc_min_ps(trc), .tals_ps(tals),
    .tds_ps(tds), .tdh_ps(tdh), .twb_ps(twb), .tr_ps(tr), .trea_ps(trea),
    .busy(busy), .done(done), .clk_sel(clk_sel), .wstrobe_dly(wstrobe_dly),
    .addr_cyc(addr_cyc), .dsetup_cyc(dsetup_cyc), .dhold_cyc(dhold_cyc),
    .busy_tmo(busy_tmo), .half_per(half_per), .dll_en(dll_en), .rdn_factor(rdn_factor)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  bit m_busy = 0, m_done = 0;
  int m_cnt = 0;
  longint unsigned p_sel, p_wd, p_als, p_ds, p_dh, p_bt, p_half, p_dll, p_f;
  longint unsigned e_sel = 0, e_wd = 0, e_als = 0, e_ds = 0, e_dh = 0, e_bt = 0,
                   e_half = 0, e_dll = 0, e_f = 0;

  function automatic longint unsigned cdiv(longint unsigned a, longint unsigned p);
    return (a + p - 1) / p;
  endfunction

  task automatic model_compute();
    longint unsigned per, rp, pulse, budget;
    bit hf;
    if (trc >= 30000) begin per = 64'd1000000000000 / 22000000; p_sel = 0; p_wd = 1; end
    else if (trc >= 25000) begin per = 64'd1000000000000 / 80000000; p_sel = 1; p_wd = 0; end
    else begin per = 64'd1000000000000 / 100000000; p_sel = 2; p_wd = 0; end
    hf = per > 16000;
    rp = hf ? per / 2 : per;
    p_als = cdiv(tals, per);
    p_ds  = cdiv(tds, per);
    p_dh  = cdiv(tdh, per);
    p_bt  = (cdiv(longint'(twb) + longint'(tr), per) * 4096) & 64'hFFFF_FFFF;
    pulse = p_ds * per;
    budget = longint'(trea) + 4000;
    p_f   = (budget > pulse) ? ((budget - pulse) * 8) / rp : 0;
    p_dll = (p_f != 0);
    p_half = (hf && p_f != 0);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0;
      e_sel = 0; e_wd = 0; e_als = 0; e_ds = 0; e_dh = 0; e_bt = 0; e_half = 0; e_dll = 0; e_f = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1;
          e_sel = p_sel; e_wd = p_wd; e_als = p_als; e_ds = p_ds; e_dh = p_dh;
          e_bt = p_bt; e_half = p_half; e_dll = p_dll; e_f = p_f;
        end
      end else if (start) begin
        model_compute();
        m_busy = 1; m_cnt = LAT;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(done == m_done, "R8 done", done, m_done);
      chk(busy == m_busy, "R8 busy", busy, m_busy);
      chk(clk_sel == e_sel[1:0] && wstrobe_dly == e_wd[0], "R1/R2 mode",
          {clk_sel, wstrobe_dly}, {e_sel[1:0], e_wd[0]});
      chk(addr_cyc == e_als[31:0], "R3 addr", addr_cyc, e_als);
      chk(dsetup_cyc == e_ds[31:0], "R3 setup", dsetup_cyc, e_ds);
      chk(dhold_cyc == e_dh[31:0], "R3 hold", dhold_cyc, e_dh);
      chk(busy_tmo == e_bt[31:0], "R4 busy timeout", busy_tmo, e_bt);
      chk(half_per == e_half[0], "R5/R7 half", half_per, e_half);
      chk(rdn_factor == e_f[31:0], "R6 factor", rdn_factor, e_f);
      chk(dll_en == e_dll[0], "R7 dll", dll_en, e_dll);
    end
  end

  task automatic set_in(input int a, b, c, d, e, f, g);
    trc = a; tals = b; tds = c; tdh = d; twb = e; tr = f; trea = g;
  endtask

  task automatic run_case(input int a, b, c, d, e, f, g);
    @(negedge clk);
    set_in(a, b, c, d, e, f, g);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    set_in(0, 0, 0, 0, 0, 0, 0);
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    set_in(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R10: reset values
    chk({busy, done, clk_sel, wstrobe_dly, half_per, dll_en} == '0, "R10 flags",
        {busy, done, clk_sel, wstrobe_dly, half_per, dll_en}, 0);
    chk((addr_cyc | dsetup_cyc | dhold_cyc | busy_tmo | rdn_factor) == 0, "R10 counts",
        addr_cyc | dsetup_cyc | dhold_cyc | busy_tmo | rdn_factor, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_case(50000, 50000, 40000, 20000, 200000, 25000000, 40000); // R1, R6 zero
    run_case(30000, 45454, 10000, 45455, 100000, 1000000, 60000);  // R1 boundary, R5 half
    run_case(29999, 6000, 10000, 12500, 100000, 0, 20000);         // R2 mid
    run_case(25000, 25001, 12501, 0, 0, 0, 0);                     // R2 boundary, R3 zero
    run_case(24999, 0, 20000, 5000, 100000, 100000, 16000);        // R2 fast, R6 exact zero
    run_case(20000, 15000, 7000, 10001, 100000, 25000000, 16000);  // R6 factor 8
    run_case(10000, 1, 1, 1, 32'h0010_0000, 32'hFFFF_0000, 32'hFFFF_FFFF); // R4 wide sum
    // R9: start while busy is ignored, inputs changing mid-run have no effect
    @(negedge clk);
    set_in(50000, 90000, 10000, 1000, 200000, 300000, 60000);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    set_in(12000, 70000, 30000, 9000, 1, 1, 100000);
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk(addr_cyc == 2 && clk_sel == 0, "R9 first run kept", addr_cyc, 2);
    repeat (LAT + 10) @(negedge clk);
    chk(addr_cyc == 2 && !busy, "R9 second start dropped", addr_cyc, 2);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule